// File: doc/BRIEF.md
# Binary-Field Inverter with Addition-Chain Exponentiation

This block returns the multiplicative inverse of an element of GF(2^M) in polynomial basis. It raises the operand to the power 2^M − 2 without a general exponentiation loop. Instead it builds the value beta^(2^n − 1) for a growing length n, which starts at 1 and ends at M − 1. Each step either doubles n or adds one to it, and the steps follow the binary digits of M − 1 from the most significant digit down. One final squaring then gives beta^(2^M − 2).

A doubling step squares the current value n times and multiplies the result by the value held before the squaring. An increment step squares once and multiplies by the original operand. Squaring uses a bit-parallel unit that gives one result per cycle. Multiplication goes to a shared bit-serial unit through a request and acknowledge handshake. For the default M = 283, the lengths visited are 1, 2, 4, 8, 16, 17, 34, 35, 70, 140, 141 and 282, which takes 11 multiplications and 282 squarings. A zero operand returns zero without running the chain.

Top module: `gf_fermat_inv`

## Requirements
- R1: For every nonzero operand, the value on res_o when done_o pulses, multiplied in GF(2^M) by the operand (reduction polynomial x^M + POLY), gives 1.
- R2: A start with operand zero gives done_o high with res_o equal to zero on the first clock edge after the edge that samples start_i, and busy_o stays low.
- R3: For nonzero operands, the number of cycles from start to done is the same for every operand value. One inverse issues exactly (floor(log2(M−1))) + (popcount(M−1) − 1) multiplications, which is 11 for M = 283.
- R4: While busy_o is high, start_i and op_i are ignored. The run that is in progress still ends with the inverse of its own operand, at its normal latency.
- R5: done_o is a single-cycle pulse, and res_o keeps its value in every cycle where done_o is low.
- R6: For a nonzero operand, busy_o is high from the edge after start until the edge on which done_o rises, and busy_o and done_o are never high together.
- R7: After reset, busy_o, done_o and res_o are all zero.
- R8: One inverse uses exactly M − 1 squarings: M − 2 inside the chain and one final squaring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an inversion of op_i (honoured only when idle) |
| op_i | input | M | Operand, polynomial basis |
| busy_o | output | 1 | Inversion in progress |
| done_o | output | 1 | One-cycle pulse, res_o valid |
| res_o | output | M | Inverse of the last accepted operand |

## Verification
The bench builds two instances. The first uses M = 8 with the reduction terms 0x1B. At this size every one of the 256 operands is swept, and the inverse expected for each one is found by an arithmetic search in the bench. The second uses the default M = 283. There the bench checks the full chain of eleven multiplications on a few sparse and dense operands, by multiplying each result back in a field routine of the bench's own. On the small instance the bench also measures the latency of a zero operand, checks that a start issued in the middle of a run is ignored, and confirms that the latency is the same for every nonzero operand.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQR,
    ST_MUL,
    ST_WAIT,
    ST_FIN
  } inv_state_e;

  function automatic int popcount_int(input int v);
    int c;
    c = 0;
    for (int i = 0; i < 31; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // index of highest set bit
  function automatic int msb_int(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) if (((v >> i) & 1) != 0) r = i;
    return r;
  endfunction

endpackage

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int          M    = 283,
  parameter logic [M-1:0] POLY = M'(13'h10A1)
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] y_o
);

  localparam int WW = 2 * M - 1;

  logic [WW-1:0] wide;

  always_comb begin
    wide = '0;
    for (int i = 0; i < M; i++) wide[2*i] = a_i[i];
    // fold high terms down, top first
    for (int k = WW - 1; k >= M; k--) begin
      if (wide[k]) begin
        wide[k] = 1'b0;
        wide[k-M +: M] = wide[k-M +: M] ^ POLY;
      end
    end
  end

  assign y_o = wide[M-1:0];

endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
  parameter int           M    = 283,
  parameter logic [M-1:0] POLY = M'(13'h10A1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         ack_o,
  output logic [M-1:0] p_o
);

  localparam int CW = $clog2(M + 1);

  logic [M-1:0]  a_q, b_q, p_q, p_nx;
  logic [CW-1:0] cnt_q;
  logic          run_q, ack_q;

  // MSB-first: p = p*x mod f + b_bit*a
  always_comb begin
    p_nx = {p_q[M-2:0], 1'b0};
    if (p_q[M-1]) p_nx = p_nx ^ POLY;
    if (b_q[M-1]) p_nx = p_nx ^ a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      p_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (!run_q) begin
        if (req_i) begin
          a_q   <= a_i;
          b_q   <= b_i;
          p_q   <= '0;
          cnt_q <= CW'(M);
          run_q <= 1'b1;
        end
      end else begin
        p_q   <= p_nx;
        b_q   <= {b_q[M-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          ack_q <= 1'b1;
        end
      end
    end
  end

  assign ack_o = ack_q;
  assign p_o   = p_q;

  AST_MUL_NO_REQ_WHILE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !req_i); // R3
  AST_MUL_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q); // R3

endmodule

// File: rtl/gf_fermat_inv.sv
module gf_fermat_inv
  import gf_inv_pkg::*;
#(
  parameter int           M    = 283,
  parameter logic [M-1:0] POLY = M'(13'h10A1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] op_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [M-1:0] res_o
);

  localparam int BW      = $clog2(M);
  localparam int NW      = $clog2(M) + 1;
  localparam int EXP_LEN = M - 1;
  localparam int TOP_BIT = msb_int(EXP_LEN);
  localparam int N_MUL   = TOP_BIT + popcount_int(EXP_LEN) - 1;
  localparam logic [BW-1:0] CHAIN = BW'(EXP_LEN);

  inv_state_e    state_q;
  logic [M-1:0]  beta_q, acc_q, tmp_q, res_q, sq_y, mul_p, mul_b;
  logic [NW-1:0] n_q, sq_cnt_q, n_nx;
  logic [BW-1:0] bit_q;
  logic          add_q, busy_q, done_q, mul_req, mul_ack;

  gf_sqr #(.M(M), .POLY(POLY)) u_sqr (
    .a_i (tmp_q),
    .y_o (sq_y)
  );

  assign mul_req = (state_q == ST_MUL);
  assign mul_b   = add_q ? beta_q : acc_q;

  gf_mul_serial #(.M(M), .POLY(POLY)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (mul_req),
    .a_i    (tmp_q),
    .b_i    (mul_b),
    .ack_o  (mul_ack),
    .p_o    (mul_p)
  );

  assign n_nx = add_q ? (n_q + 1'b1) : {n_q[NW-2:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      beta_q   <= '0;
      acc_q    <= '0;
      tmp_q    <= '0;
      res_q    <= '0;
      n_q      <= '0;
      sq_cnt_q <= '0;
      bit_q    <= '0;
      add_q    <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (op_i == '0) begin
              res_q  <= '0;
              done_q <= 1'b1;
            end else begin
              beta_q   <= op_i;
              acc_q    <= op_i;
              tmp_q    <= op_i;
              n_q      <= NW'(1);
              sq_cnt_q <= NW'(1);
              bit_q    <= BW'(TOP_BIT - 1);
              add_q    <= 1'b0;
              busy_q   <= 1'b1;
              state_q  <= ST_SQR;
            end
          end
        end
        ST_SQR: begin
          tmp_q    <= sq_y;
          sq_cnt_q <= sq_cnt_q - 1'b1;
          if (sq_cnt_q == NW'(1)) state_q <= ST_MUL;
        end
        ST_MUL: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mul_ack) begin
            acc_q <= mul_p;
            tmp_q <= mul_p;
            n_q   <= n_nx;
            if (!add_q && CHAIN[bit_q]) begin
              add_q    <= 1'b1;
              sq_cnt_q <= NW'(1);
              state_q  <= ST_SQR;
            end else if (bit_q == '0) begin
              state_q <= ST_FIN;
            end else begin
              bit_q    <= bit_q - 1'b1;
              add_q    <= 1'b0;
              sq_cnt_q <= n_nx;
              state_q  <= ST_SQR;
            end
          end
        end
        ST_FIN: begin
          res_q   <= sq_y;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign res_o  = res_q;

  // operation tallies, observed by assertions only
  logic [15:0] mul_tally_q, sq_tally_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_tally_q <= '0;
      sq_tally_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      mul_tally_q <= '0;
      sq_tally_q  <= '0;
    end else begin
      if (mul_ack) mul_tally_q <= mul_tally_q + 1'b1;
      if (state_q == ST_SQR) sq_tally_q <= sq_tally_q + 1'b1;
    end
  end

  AST_MUL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN) |-> (mul_tally_q == 16'(N_MUL))); // R3
  AST_SQR_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN) |-> (sq_tally_q == 16'(M - 2))); // R8
  AST_SQR_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SQR) |-> (sq_cnt_q != '0)); // R8
  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && op_i == '0) |=> (done_o && res_o == '0 && !busy_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o)); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_FIN) |=> busy_o); // R4

endmodule

// File: tb/tb_gf_fermat_inv.sv
module tb_gf_fermat_inv;

  localparam int MS = 8;
  localparam int ML = 283;
  localparam logic [MS-1:0] POLY_S = 8'h1B;
  localparam logic [ML-1:0] POLY_L = ML'(13'h10A1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          s_start = 1'b0;
  logic [MS-1:0] s_op = '0;
  logic          s_busy, s_done;
  logic [MS-1:0] s_res;

  logic          l_start = 1'b0;
  logic [ML-1:0] l_op = '0;
  logic          l_busy, l_done;
  logic [ML-1:0] l_res;

  int n_chk = 0;
  int n_bad = 0;

  gf_fermat_inv #(.M(MS), .POLY(POLY_S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .op_i(s_op),
    .busy_o(s_busy), .done_o(s_done), .res_o(s_res)
  );

  gf_fermat_inv #(.M(ML), .POLY(POLY_L)) dut_wide (
    .clk_i(clk), .rst_ni(rst_n), .start_i(l_start), .op_i(l_op),
    .busy_o(l_busy), .done_o(l_done), .res_o(l_res)
  );

  function automatic logic [ML-1:0] fmul(input logic [ML-1:0] a, input logic [ML-1:0] b,
                                         input logic [ML-1:0] poly, input int m);
    logic [ML-1:0] p;
    logic          hi;
    p = '0;
    for (int i = m - 1; i >= 0; i--) begin
      hi = p[m-1];
      p = p << 1;
      p[m] = 1'b0;
      if (hi) p = p ^ poly;
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [ML-1:0] act, input logic [ML-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_s(input logic [MS-1:0] op, input int poke, output logic [MS-1:0] res,
                       output int lat);
    @(negedge clk);
    s_start = 1'b1;
    s_op = op;
    @(negedge clk);
    s_start = 1'b0;
    lat = 1;
    while (!s_done && lat < 5000) begin
      if (lat == poke) begin
        s_start = 1'b1;
        s_op = op ^ 8'h5A;
      end else begin
        s_start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    s_start = 1'b0;
    res = s_res;
  endtask

  task automatic run_l(input logic [ML-1:0] op, output logic [ML-1:0] res, output int lat);
    @(negedge clk);
    l_start = 1'b1;
    l_op = op;
    @(negedge clk);
    l_start = 1'b0;
    lat = 1;
    while (!l_done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    res = l_res;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [MS-1:0] r8, exp8;
    logic [ML-1:0] rl;
    int lat, lat_ref, lat_l_ref;
    logic [ML-1:0] wops[4];

    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 busy", ML'(s_busy), '0);
    check("R7 done", ML'(s_done), '0);
    check("R7 res", ML'(s_res), '0);
    check("R7 wide res", l_res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 zero operand
    run_s('0, -1, r8, lat);
    check("R2 zero res", ML'(r8), '0);
    check("R2 zero latency", ML'(lat), ML'(1));
    check("R2 busy low", ML'(s_busy), '0);

    // R1/R3/R5/R6 full sweep of M=8
    lat_ref = -1;
    for (int x = 1; x < 256; x++) begin
      exp8 = '0;
      for (int y = 1; y < 256; y++)
        if (fmul(ML'(x), ML'(y), ML'(POLY_S), MS) == ML'(1)) exp8 = MS'(y);
      @(negedge clk);
      s_start = 1'b1;
      s_op = MS'(x);
      @(negedge clk);
      s_start = 1'b0;
      check("R6 busy after start", ML'(s_busy), ML'(1));
      lat = 1;
      while (!s_done && lat < 5000) begin
        @(negedge clk);
        lat++;
      end
      check("R1 inverse", ML'(s_res), ML'(exp8));
      check("R6 busy at done", ML'(s_busy), '0);
      if (lat_ref < 0) lat_ref = lat;
      check("R3 latency", ML'(lat), ML'(lat_ref));
      r8 = s_res;
      @(negedge clk);
      check("R5 done pulse", ML'(s_done), '0);
      repeat (2) @(negedge clk);
      check("R5 res held", ML'(s_res), ML'(r8));
    end

    // R4 start during busy ignored
    run_s(8'h03, 4, r8, lat);
    exp8 = '0;
    for (int y = 1; y < 256; y++)
      if (fmul(ML'(3), ML'(y), ML'(POLY_S), MS) == ML'(1)) exp8 = MS'(y);
    check("R4 result kept", ML'(r8), ML'(exp8));
    check("R4 latency kept", ML'(lat), ML'(lat_ref));
    @(negedge clk);
    check("R4 no restart", ML'(s_busy), '0);

    // R1/R3/R8 default width
    wops[0] = ML'(1);
    wops[1] = ML'(2);
    wops[2] = {1'b1, {(ML-1){1'b0}}};
    wops[3] = {ML{1'b1}} ^ (ML'(64'h0123_4567_89AB_CDEF) << 100);
    lat_l_ref = -1;
    for (int k = 0; k < 4; k++) begin
      run_l(wops[k], rl, lat);
      check("R1 wide inverse", fmul(wops[k], rl, POLY_L, ML), ML'(1));
      if (lat_l_ref < 0) lat_l_ref = lat;
      check("R3 wide latency", ML'(lat), ML'(lat_l_ref));
    end
    check("R8 wide inv of one", rl == '0 ? ML'(0) : ML'(1), ML'(1));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule